// File: doc/BRIEF.md
# Serial Bootstrap Upload Loader

This block decides, once per reset, how a small processor starts. On the clock edge where reset is released it reads two mode-select pins. The result is one of four start modes. The first mode jumps straight into RAM. The second asks for a selftest. The third receives a program over a serial receive line, stores it in RAM and then jumps to it. The fourth hands control to an external hexdump responder. The RAM, the processor and the responder are outside the block. The loader only drives a RAM write port, a one-cycle jump strobe with its target address, and one status output per mode.

In upload mode the loader takes exactly `LOAD_LEN` bytes, 512 by default. It writes them in arrival order, starting at `BASE_ADDR` (0040h), so the default program fills 0040h to 023Fh. It never answers on its transmit line. In the cycle right after the final byte is written it pulses the jump strobe. After that it stays idle until the next reset.

The sequencer has six states:
- `B_WAIT` is held during reset.
- `B_JUMP` lasts one cycle and carries the strobe.
- `B_TEST` holds the selftest request.
- `B_LOAD` receives and writes bytes.
- `B_DUMP` holds the hexdump enable.
- `B_HALT` is the final idle state.

The transitions are:
- From `B_WAIT`, on the first edge with reset high, the pin code selects the next state: 0 goes to `B_JUMP`, 1 to `B_TEST`, 2 to `B_LOAD` and 3 to `B_DUMP`.
- From `B_LOAD`, a good final byte goes to `B_JUMP`.
- From `B_JUMP`, the next cycle always goes to `B_HALT`.
- `B_TEST`, `B_DUMP` and `B_HALT` hold until reset.

The receiver has four states: `RX_IDLE`, `RX_START` (check at mid-bit), `RX_DATA` and `RX_STOP`.

Top module: `boot_loader`

## Requirements
- R1: The mode is taken from `mode_sel` only on the first rising clock edge with `rst_n` high. Later changes on `mode_sel` have no effect until the next reset. The encoding is `mode_sel` = 0 for jump, 1 for selftest, 2 for upload and 3 for hexdump.
- R2: In mode 0, `jump_stb` is high for exactly one cycle, in the cycle right after reset release, with `jump_addr` = 0040h. No RAM write happens.
- R3: In mode 1, `selftest_req` goes high and stays high until reset. There is no RAM write and no jump.
- R4: In mode 3, `hexdump_en` goes high and stays high until reset. There is no RAM write and no jump.
- R5: In mode 2, `upload_busy` is high while loading. Exactly `LOAD_LEN` bytes (512) are written in order, to addresses `BASE_ADDR`+k, which is 0040h through 023Fh. Each write is one `wr_en` cycle with `wr_addr` and `wr_data` valid.
- R6: Each serial byte has one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit lasts `PRE_DIV*BAUD_DIV` clocks (2*208 by default).
- R7: `jump_stb` rises in the cycle right after the final write, with `jump_addr` = 0040h, and lasts one cycle. Afterwards no status output is active and received bytes cause no writes.
- R8: A start bit that is no longer low at its mid-point is dropped without a write.
- R9: A byte whose stop bit is low is dropped and does not advance the write address. It also sets `frame_err`, which stays high until reset.
- R10: `tx` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Start-mode pins, sampled at reset release |
| rx | input | 1 | Serial receive line, idle high |
| tx | output | 1 | Serial transmit line, held idle |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 16 | RAM write address |
| wr_data | output | 8 | RAM write data |
| jump_stb | output | 1 | One-cycle jump request |
| jump_addr | output | 16 | Jump target, valid with `jump_stb` |
| selftest_req | output | 1 | Selftest requested (mode 1) |
| hexdump_en | output | 1 | External hexdump responder enabled (mode 3) |
| upload_busy | output | 1 | Upload in progress (mode 2) |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume three things about the inputs:
- `mode_sel` is stable on the reset-release edge.
- Serial bytes arrive at the configured bit period with full-length bits.
- The line returns high between frames, so that each frame begins with a real falling edge.

The stimulus keeps within these limits. It changes `mode_sel` only while reset is held low, or once a mode is already latched. It drives every bit for exactly the configured number of clocks, and it inserts a full idle bit after each frame. The glitch and bad-stop-bit cases are deliberate departures from these limits and are kept inside the upload run. That shows how they affect the write address.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [2:0] {
        B_WAIT,
        B_JUMP,
        B_TEST,
        B_LOAD,
        B_DUMP,
        B_HALT
    } boot_st_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_t;

    typedef enum logic [1:0] {
        M_JUMP = 2'd0,
        M_TEST = 2'd1,
        M_LOAD = 2'd2,
        M_DUMP = 2'd3
    } mode_t;

endpackage

// File: rtl/boot_uart_rx.sv
module boot_uart_rx
    import boot_pkg::*;
#(
    parameter int PRE_DIV     = 2,
    parameter int BAUD_DIV    = 208,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       byte_ferr
);
    localparam int BIT_CYC = PRE_DIV * BAUD_DIV;
    localparam int HALF    = BIT_CYC / 2;
    localparam int CW      = $clog2(BIT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_st_t                 st_q, st_nx;
    logic [CW-1:0]          cnt_q;
    logic [2:0]             bit_q;
    logic [7:0]             shf_q;
    logic                   at_half, at_full;

    // input synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx};
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    assign at_half = (cnt_q == CW'(HALF - 1));
    assign at_full = (cnt_q == CW'(BIT_CYC - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            RX_IDLE:  if (!rx_s) st_nx = RX_START;
            RX_START: if (at_half) st_nx = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (at_full && bit_q == 3'd7) st_nx = RX_STOP;
            RX_STOP:  if (at_full) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    // bit timing and shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            shf_q <= '0;
        end else begin
            unique case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    bit_q <= '0;
                end
                RX_START: cnt_q <= at_half ? '0 : cnt_q + 1'b1;
                RX_DATA: begin
                    if (at_full) begin
                        cnt_q <= '0;
                        bit_q <= bit_q + 3'd1;
                        shf_q <= {rx_s, shf_q[7:1]};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: cnt_q <= at_full ? '0 : cnt_q + 1'b1;
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs, registered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            byte_ferr <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld  <= (st_q == RX_STOP) && at_full && rx_s;
            byte_ferr <= (st_q == RX_STOP) && at_full && !rx_s;
            if ((st_q == RX_STOP) && at_full) byte_data <= shf_q;
        end
    end

endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int          LOAD_LEN  = 512,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              byte_ferr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              jump_stb,
    output logic [ADDR_W-1:0] jump_addr,
    output logic              selftest_req,
    output logic              hexdump_en,
    output logic              upload_busy,
    output logic              frame_err
);
    localparam int NW = $clog2(LOAD_LEN + 1);

    boot_st_t       st_q, st_nx;
    logic [NW-1:0]  cnt_q;
    logic           ferr_q;
    logic           last_byte;

    assign last_byte = byte_vld && (cnt_q == NW'(LOAD_LEN - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= B_WAIT;
        else        st_q <= st_nx;
    end

    // byte counter and sticky framing flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ferr_q <= 1'b0;
        end else if (st_q == B_LOAD) begin
            if (byte_vld)  cnt_q  <= cnt_q + 1'b1;
            if (byte_ferr) ferr_q <= 1'b1;
        end
    end

    // transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            B_WAIT: begin
                unique case (mode_t'(mode_sel))
                    M_JUMP: st_nx = B_JUMP;
                    M_TEST: st_nx = B_TEST;
                    M_LOAD: st_nx = B_LOAD;
                    M_DUMP: st_nx = B_DUMP;
                    default: st_nx = B_HALT;
                endcase
            end
            B_LOAD:  if (last_byte) st_nx = B_JUMP;
            B_JUMP:  st_nx = B_HALT;
            B_TEST,
            B_DUMP,
            B_HALT:  st_nx = st_q;
            default: st_nx = B_HALT;
        endcase
    end

    // outputs
    always_comb begin
        wr_en        = 1'b0;
        jump_stb     = 1'b0;
        jump_addr    = '0;
        selftest_req = 1'b0;
        hexdump_en   = 1'b0;
        upload_busy  = 1'b0;
        unique case (st_q)
            B_LOAD: begin
                upload_busy = 1'b1;
                wr_en       = byte_vld;
            end
            B_JUMP: begin
                jump_stb  = 1'b1;
                jump_addr = ADDR_W'(BASE_ADDR);
            end
            B_TEST: selftest_req = 1'b1;
            B_DUMP: hexdump_en   = 1'b1;
            B_WAIT,
            B_HALT: ;
            default: ;
        endcase
    end

    assign wr_addr   = ADDR_W'(BASE_ADDR) + ADDR_W'(cnt_q);
    assign wr_data   = byte_data;
    assign frame_err = ferr_q;

endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_pkg::*;
#(
    parameter int          PRE_DIV   = 2,
    parameter int          BAUD_DIV  = 208,
    parameter int          LOAD_LEN  = 512,
    parameter logic [15:0] BASE_ADDR = 16'h0040
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_sel,
    input  logic        rx,
    output logic        tx,
    output logic        wr_en,
    output logic [15:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        jump_stb,
    output logic [15:0] jump_addr,
    output logic        selftest_req,
    output logic        hexdump_en,
    output logic        upload_busy,
    output logic        frame_err
);
    logic       byte_vld;
    logic       byte_ferr;
    logic [7:0] byte_data;

    boot_uart_rx #(
        .PRE_DIV    (PRE_DIV),
        .BAUD_DIV   (BAUD_DIV),
        .SYNC_STAGES(2)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx),
        .byte_vld (byte_vld),
        .byte_data(byte_data),
        .byte_ferr(byte_ferr)
    );

    boot_seq #(
        .LOAD_LEN (LOAD_LEN),
        .ADDR_W   (16),
        .BASE_ADDR(BASE_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .byte_ferr   (byte_ferr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .jump_stb    (jump_stb),
        .jump_addr   (jump_addr),
        .selftest_req(selftest_req),
        .hexdump_en  (hexdump_en),
        .upload_busy (upload_busy),
        .frame_err   (frame_err)
    );

    // transmit line never leaves idle
    assign tx = 1'b1;

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int          LOAD_LEN  = 512,
    parameter logic [15:0] BASE_ADDR = 16'h0040
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic        jump_stb,
    input logic [15:0] jump_addr,
    input logic        selftest_req,
    input logic        hexdump_en,
    input logic        upload_busy,
    input logic        frame_err
);
    // R5: writes only happen during an upload
    p_wr_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> upload_busy);

    // R5: every write address lies inside the load window
    p_wr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((int'(wr_addr) >= int'(BASE_ADDR)) &&
                   (int'(wr_addr) <  int'(BASE_ADDR) + LOAD_LEN)));

    // R7: the jump strobe lasts a single cycle
    p_jump_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_stb |=> !jump_stb);

    // R2: the target address comes with the strobe
    p_jump_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        jump_stb |-> (jump_addr == BASE_ADDR));

    // R7: nothing is active after the jump
    p_after_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_stb |=> !(upload_busy || selftest_req || hexdump_en));

    // R1: at most one mode indication at a time
    p_one_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jump_stb, selftest_req, hexdump_en, upload_busy}));

    // R3: selftest request holds until reset
    p_test_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_req |=> selftest_req);

    // R4: hexdump enable holds until reset
    p_dump_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hexdump_en |=> hexdump_en);

    // R9: framing flag is sticky
    p_ferr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

bind boot_loader boot_loader_chk #(
    .LOAD_LEN (LOAD_LEN),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .jump_stb    (jump_stb),
    .jump_addr   (jump_addr),
    .selftest_req(selftest_req),
    .hexdump_en  (hexdump_en),
    .upload_busy (upload_busy),
    .frame_err   (frame_err)
);

// File: tb/boot_loader_test.sv
module boot_loader_test;
    localparam int PRE  = 2;
    localparam int BAUD = 4;
    localparam int BITC = PRE * BAUD;
    localparam int LEN  = 512;
    localparam logic [15:0] BASE = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        rx = 1'b1;
    logic        tx, wr_en, jump_stb, selftest_req, hexdump_en, upload_busy, frame_err;
    logic [15:0] wr_addr, jump_addr;
    logic [7:0]  wr_data;

    int n_run = 0, n_fail = 0;
    int cyc = 0, nwr = 0, njmp = 0, last_wr_cyc = -1, jump_cyc = -1, tx_bad = 0;
    logic [15:0] jaddr;
    logic [15:0] got_a [0:1023];
    logic [7:0]  got_d [0:1023];
    bit done = 0;

    always #5 clk = ~clk;

    boot_loader #(.PRE_DIV(PRE), .BAUD_DIV(BAUD), .LOAD_LEN(LEN), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx(rx), .tx(tx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .jump_stb(jump_stb), .jump_addr(jump_addr),
        .selftest_req(selftest_req), .hexdump_en(hexdump_en),
        .upload_busy(upload_busy), .frame_err(frame_err));

    // monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (tx !== 1'b1) tx_bad++;
        if (rst_n && wr_en === 1'b1) begin
            if (nwr < 1024) begin
                got_a[nwr] = wr_addr;
                got_d[nwr] = wr_data;
            end
            nwr++;
            last_wr_cyc = cyc;
        end
        if (rst_n && jump_stb === 1'b1) begin
            njmp++;
            jump_cyc = cyc;
            jaddr = jump_addr;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k) ^ ((k >= 256) ? 8'hC3 : 8'h00);
    endfunction

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = m;
        rx = 1'b1;
        repeat (3) @(negedge clk);
        nwr = 0; njmp = 0; last_wr_cyc = -1; jump_cyc = -1; tx_bad = 0;
        rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_bit);
        rx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx = stop_bit;
        repeat (BITC) @(negedge clk);
        rx = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    initial begin
        // ---------- reset state (R10, R5) ----------
        rst_n = 1'b0;
        mode_sel = 2'd2;
        repeat (3) @(negedge clk);
        check(!wr_en && !jump_stb && !selftest_req && !hexdump_en && !upload_busy && !frame_err,
              "reset state", {wr_en, jump_stb, selftest_req, hexdump_en, upload_busy}, 0);
        check(tx === 1'b1, "R10 tx idle in reset", tx, 1);

        // ---------- mode 2 upload ----------
        do_reset(2'd2);
        @(negedge clk);
        check(upload_busy === 1'b1, "R5 busy after release", upload_busy, 1);
        // R8: short low pulse
        rx = 1'b0;
        repeat (2) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        check(nwr == 0, "R8 glitch dropped", nwr, 0);
        // R9: bad stop bit
        send_byte(8'hA5, 1'b0);
        repeat (BITC) @(negedge clk);
        check(nwr == 0, "R9 bad frame no write", nwr, 0);
        check(frame_err === 1'b1, "R9 frame_err set", frame_err, 1);
        for (int k = 0; k < LEN; k++) send_byte(pat(k), 1'b1);
        repeat (4) @(negedge clk);
        check(nwr == LEN, "R5 write count", nwr, LEN);
        for (int k = 0; k < LEN && k < nwr; k++) begin
            check(got_a[k] == BASE + 16'(k), "R5 write address (R9 no skip)", got_a[k], BASE + k);
            check(got_d[k] == pat(k), "R6 write data LSB first", got_d[k], pat(k));
        end
        check(njmp == 1, "R7 one jump", njmp, 1);
        check(jaddr == BASE, "R7 jump address", jaddr, BASE);
        check(jump_cyc == last_wr_cyc + 1, "R7 jump follows last write", jump_cyc, last_wr_cyc + 1);
        check(frame_err === 1'b1, "R9 frame_err sticky", frame_err, 1);
        send_byte(8'h3C, 1'b1);
        check(nwr == LEN && !upload_busy && !selftest_req && !hexdump_en,
              "R7 idle after jump", nwr, LEN);
        check(tx_bad == 0, "R10 tx stayed high", tx_bad, 0);

        // ---------- mode 0 ----------
        do_reset(2'd0);
        @(negedge clk);
        check(jump_stb === 1'b1 && jump_addr == BASE, "R2 jump after release", jump_addr, BASE);
        @(negedge clk);
        check(jump_stb === 1'b0, "R2 single-cycle strobe", jump_stb, 0);
        send_byte(8'h11, 1'b1);
        check(nwr == 0 && njmp == 1, "R2 no writes", nwr, 0);

        // ---------- mode 1, pins changed later ----------
        do_reset(2'd1);
        @(negedge clk);
        check(selftest_req === 1'b1 && !hexdump_en, "R3 selftest raised", selftest_req, 1);
        mode_sel = 2'd2;
        send_byte(8'h22, 1'b1);
        check(nwr == 0 && njmp == 0, "R3 no write or jump", nwr, 0);
        check(selftest_req === 1'b1 && !upload_busy, "R1 late pin change ignored", upload_busy, 0);

        // ---------- mode 3, pins changed later ----------
        do_reset(2'd3);
        @(negedge clk);
        check(hexdump_en === 1'b1 && !selftest_req, "R4 hexdump raised", hexdump_en, 1);
        mode_sel = 2'd0;
        send_byte(8'h44, 1'b1);
        check(nwr == 0 && njmp == 0, "R4 no write or jump", njmp, 0);
        check(hexdump_en === 1'b1, "R1 mode held after pin change", hexdump_en, 1);
        check(tx_bad == 0, "R10 tx high in other modes", tx_bad, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule